// File: doc/BRIEF.md
# NAND Page ECC Outcome Evaluator

This block interprets the correction status that a BCH-protected NAND page read leaves behind and turns it into a bitflip figure plus running statistics. A start pulse captures three values: a flag saying the page was detected as blank, a 16-bit correction report, and the configured correction strength. When the report shows that every packet decoded, the block reads the two per-packet counts and finishes on the next cycle.

The decoder does not catch bitflips in erased pages. When the report signals a decode failure, the block therefore raises a bad-message indication and asks for the raw page as a byte stream. It counts zero bits packet by packet and decides for each packet whether it is still an erased packet with a few flipped bits or a real failure. The corrected-bits accumulator and the failed-packet counter persist across pages. The per-page maximum and the bad-message flag are cleared by each start.

Top module: `ecc_result_eval`

## Requirements
- R1: While reset is low and right after it, `done`, `s_ready`, `bad_msg`, `max_flips`, `corr_acc` and `fail_cnt` are all zero.
- R2: If `page_empty` is high when start is captured, the page result is `max_flips`=0 and `bad_msg`=0, and the accumulator and failure counter stay unchanged, whatever the report word holds.
- R3: Report bits [5:0] hold the first packet's corrected count and bits [13:8] hold the largest count among the remaining packets. When both bit 7 and bit 15 are 1, the sum of the two counts is added to `corr_acc` and `max_flips` becomes the larger count.
- R4: A report with bit 7 equal to 0 or bit 15 equal to 0 sets `bad_msg` and starts the raw-byte scan instead of using the counts.
- R5: During a scan, `s_ready` is high until exactly NUM_PKT packets have been accepted. Packet 0 has META_BYTES+PKT_DATA+E bytes and every later packet has PKT_DATA+E bytes, where E = ceil(strength*15/8).
- R6: Each accepted byte contributes the number of 0 bits it contains. When a packet ends with a total above strength, `fail_cnt` increments by one. Otherwise the total is added to `corr_acc`, and `max_flips` becomes the larger of itself and that total.
- R7: `done` is a single-cycle pulse. It comes one cycle after start is captured on the report path, and one cycle after the final byte is accepted on the scan path. Start clears the per-page maximum and `bad_msg`.
- R8: `corr_acc` and `fail_cnt` keep accumulating over successive pages and are cleared only by reset.
- R9: A beat with `s_valid` low is not consumed, and its data has no effect on the counts.
- R10: `max_flips` saturates at 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin evaluation of one page; sampled only when idle |
| page_empty | input | 1 | Blank-page indication from the transfer status |
| err_report | input | 16 | Per-page correction report word |
| strength | input | STR_W | Correctable bits per packet |
| s_valid | input | 1 | Raw page byte valid |
| s_data | input | 8 | Raw page byte |
| s_ready | output | 1 | Block accepts raw bytes (scan in progress) |
| done | output | 1 | One-cycle pulse: page result valid |
| bad_msg | output | 1 | Report indicated a decode failure for this page |
| max_flips | output | 6 | Largest corrected count of the page |
| corr_acc | output | ACC_W | Total corrected bits across pages |
| fail_cnt | output | FAIL_W | Packets judged uncorrectable across pages |

## Verification
On the report path, `done` and the updated outputs appear one clock edge after the edge that captures start. The bench releases start at a falling edge and checks at the following falling edge. On the scan path, `s_ready` is sampled at the falling edge before each rising edge, so the bench knows exactly which beats were consumed and can count them. The result is then checked at the first falling edge where `done` is high, which is one edge after the final accepted byte, and at the next falling edge the bench confirms that `done` has dropped.

// File: rtl/ecc_result_eval.sv
module ecc_result_eval #(
  parameter int NUM_PKT    = 4,
  parameter int PKT_DATA   = 16,
  parameter int META_BYTES = 4,
  parameter int STR_W      = 6,
  parameter int FIELD_M    = 15,
  parameter int ACC_W      = 24,
  parameter int FAIL_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              page_empty,
  input  logic [15:0]       err_report,
  input  logic [STR_W-1:0]  strength,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  output logic              s_ready,
  output logic              done,
  output logic              bad_msg,
  output logic [5:0]        max_flips,
  output logic [ACC_W-1:0]  corr_acc,
  output logic [FAIL_W-1:0] fail_cnt
);
  localparam int ECC_MAX = ((2**STR_W - 1) * FIELD_M + 7) / 8;
  localparam int LEN_W   = $clog2(META_BYTES + PKT_DATA + ECC_MAX + 1);
  localparam int ZC_W    = $clog2((META_BYTES + PKT_DATA + ECC_MAX) * 8 + 1) + 1;
  localparam int EW      = $clog2((2**STR_W - 1) * FIELD_M + 8) + 1;
  localparam int PK_W    = (NUM_PKT > 1) ? $clog2(NUM_PKT) : 1;
  localparam logic [EW-1:0] FM = EW'(FIELD_M);

  typedef enum logic [1:0] {IDLE, EVAL, SCAN, FIN} st_t;
  st_t st;

  logic             pe_q;
  logic [15:0]      rep_q;
  logic [STR_W-1:0] str_q;
  logic [PK_W-1:0]  pkt;
  logic [LEN_W-1:0] bidx;
  logic [ZC_W-1:0]  zcnt;

  logic [5:0]       c0, cn;
  logic             dec_fail;
  logic [EW-1:0]    ecc_bytes;
  logic [LEN_W-1:0] pkt_len;
  logic [ZC_W-1:0]  zfin;
  logic             last_byte, over;

  assign c0        = rep_q[5:0];
  assign cn        = rep_q[13:8];
  assign dec_fail  = !rep_q[7] || !rep_q[15];
  assign ecc_bytes = (EW'(str_q) * FM + EW'(7)) >> 3;
  assign pkt_len   = LEN_W'(PKT_DATA) + LEN_W'(ecc_bytes)
                   + ((pkt == '0) ? LEN_W'(META_BYTES) : '0);
  assign zfin      = zcnt + ZC_W'($countones(~s_data));
  assign last_byte = (bidx == pkt_len - LEN_W'(1));
  assign over      = zfin > ZC_W'(str_q);

  assign s_ready = (st == SCAN);
  assign done    = (st == FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      pe_q      <= 1'b0;
      rep_q     <= '0;
      str_q     <= '0;
      pkt       <= '0;
      bidx      <= '0;
      zcnt      <= '0;
      bad_msg   <= 1'b0;
      max_flips <= '0;
      corr_acc  <= '0;
      fail_cnt  <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          pe_q      <= page_empty;
          rep_q     <= err_report;
          str_q     <= strength;
          max_flips <= '0;
          bad_msg   <= 1'b0;
          st        <= EVAL;
        end
        EVAL: begin
          if (pe_q) begin
            st <= FIN;
          end else if (dec_fail) begin
            bad_msg <= 1'b1;
            pkt     <= '0;
            bidx    <= '0;
            zcnt    <= '0;
            st      <= SCAN;
          end else begin
            corr_acc  <= corr_acc + ACC_W'(c0) + ACC_W'(cn);
            max_flips <= (c0 > cn) ? c0 : cn;
            st        <= FIN;
          end
        end
        SCAN: if (s_valid) begin
          if (last_byte) begin
            zcnt <= '0;
            bidx <= '0;
            if (over) begin
              fail_cnt <= fail_cnt + FAIL_W'(1);
            end else begin
              corr_acc <= corr_acc + ACC_W'(zfin);
              if (zfin > ZC_W'(max_flips))
                max_flips <= (zfin > ZC_W'(63)) ? 6'd63 : zfin[5:0];
            end
            if (pkt == PK_W'(NUM_PKT - 1)) st <= FIN;
            else pkt <= pkt + PK_W'(1);
          end else begin
            zcnt <= zfin;
            bidx <= bidx + LEN_W'(1);
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module ecc_result_eval_chk #(
  parameter int ACC_W  = 24,
  parameter int FAIL_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_ready,
  input logic              done,
  input logic [5:0]        max_flips,
  input logic [ACC_W-1:0]  corr_acc,
  input logic [FAIL_W-1:0] fail_cnt
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_READY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !done); // R5
  AST_FAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_cnt == $past(fail_cnt)) || (fail_cnt == $past(fail_cnt) + FAIL_W'(1))); // R6
  AST_ACC_NONDEC: assert property (@(posedge clk) disable iff (!rst_n)
    corr_acc >= $past(corr_acc)); // R8
  AST_MAX_STABLE_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && $past(s_ready)) |-> (max_flips >= $past(max_flips))); // R6
endmodule

bind ecc_result_eval ecc_result_eval_chk #(.ACC_W(ACC_W), .FAIL_W(FAIL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .done(done),
  .max_flips(max_flips), .corr_acc(corr_acc), .fail_cnt(fail_cnt));

// File: tb/ecc_result_eval_tb.sv
module ecc_result_eval_tb_top;
  localparam int NUM_PKT = 4, PKT_DATA = 16, META = 4;

  logic clk = 0, rst_n = 0, start = 0, page_empty = 0, s_valid = 0;
  logic [15:0] err_report = '0;
  logic [5:0]  strength = '0;
  logic [7:0]  s_data = '0;
  logic s_ready, done, bad_msg;
  logic [5:0]  max_flips;
  logic [23:0] corr_acc;
  logic [15:0] fail_cnt;

  always #10 clk = ~clk;

  ecc_result_eval dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .page_empty(page_empty),
    .err_report(err_report), .strength(strength), .s_valid(s_valid),
    .s_data(s_data), .s_ready(s_ready), .done(done), .bad_msg(bad_msg),
    .max_flips(max_flips), .corr_acc(corr_acc), .fail_cnt(fail_cnt));

  int errs = 0, checks = 0;
  int exp_acc = 0, exp_fail = 0;
  int zz [4];
  int L0, Ln;
  bit finished = 0;

  // {page_empty, report, strength, expected max, expected accumulator delta}
  localparam logic [36:0] VEC [6] = '{
    {1'b1, 16'h0000, 6'd8, 6'd0,  8'd0},
    {1'b0, 16'h8385, 6'd8, 6'd5,  8'd8},
    {1'b0, 16'h8A80, 6'd8, 6'd10, 8'd10},
    {1'b0, 16'hBFBF, 6'd8, 6'd63, 8'd126},
    {1'b0, 16'h8080, 6'd8, 6'd0,  8'd0},
    {1'b1, 16'hBFBF, 6'd8, 6'd0,  8'd0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_start(input bit pe, input logic [15:0] rep, input logic [5:0] s);
    @(negedge clk);
    page_empty = pe; err_report = rep; strength = s; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  function automatic logic [7:0] gen(input int idx);
    int p, off, z;
    if (idx < L0) begin p = 0; off = idx; end
    else begin p = 1 + (idx - L0) / Ln; off = (idx - L0) % Ln; end
    if (p > 3) return 8'hFF;
    z = zz[p];
    if (off < z / 8) return 8'h00;
    if (off == z / 8 && (z % 8) != 0) return 8'hFF << (z % 8);
    return 8'hFF;
  endfunction

  task automatic run_scan(input logic [15:0] rep, input int s, input int z0, input int z1,
                          input int z2, input int z3, input bit gaps, input string tag);
    int ecc, total, idx, mx, acc0, fail0, dacc, dfail;
    bit rdy, want, seen;
    ecc = (s * 15 + 7) / 8;
    L0 = META + PKT_DATA + ecc; Ln = PKT_DATA + ecc;
    total = L0 + 3 * Ln;
    zz[0] = z0; zz[1] = z1; zz[2] = z2; zz[3] = z3;
    mx = 0; dacc = 0; dfail = 0;
    for (int p = 0; p < 4; p++) begin
      if (zz[p] > s) dfail++;
      else begin dacc += zz[p]; if (zz[p] > mx) mx = zz[p]; end
    end
    acc0 = exp_acc; fail0 = exp_fail;
    exp_acc += dacc; exp_fail += dfail;
    do_start(1'b0, rep, 6'(s));
    idx = 0; seen = 0;
    for (int cyc = 0; cyc < 5000; cyc++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
      want = gaps ? (cyc % 3 != 0) : 1'b1;
      s_valid = want;
      s_data = want ? gen(idx) : 8'h00;
      rdy = s_ready;
      @(posedge clk);
      if (rdy && want) idx++;
    end
    s_valid = 0;
    chk(seen, {tag, " R7 done after scan"}, int'(seen), 1);
    chk(bad_msg == 1'b1, {tag, " R4 bad_msg"}, int'(bad_msg), 1);
    chk(idx == total, {tag, " R5 bytes consumed"}, idx, total);
    chk(int'(max_flips) == mx, {tag, " R6 max_flips"}, int'(max_flips), mx);
    chk(int'(corr_acc) == exp_acc, {tag, " R6 R8 corr_acc"}, int'(corr_acc), exp_acc);
    chk(int'(fail_cnt) == exp_fail, {tag, " R6 R8 fail_cnt"}, int'(fail_cnt), exp_fail);
    @(negedge clk);
    chk(!done, {tag, " R7 done single pulse"}, int'(done), 0);
    if (acc0 < 0 || fail0 < 0) $display("unreachable");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !s_ready && !bad_msg, "R1 reset control outputs", int'(done | s_ready | bad_msg), 0);
    chk(max_flips == 0 && corr_acc == 0 && fail_cnt == 0, "R1 reset counters",
        int'(corr_acc) + int'(fail_cnt) + int'(max_flips), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!done && corr_acc == 0, "R1 after reset release", int'(done), 0);

    for (int i = 0; i < 6; i++) begin
      logic [36:0] v;
      v = VEC[i];
      do_start(v[36], v[35:20], v[19:14]);
      @(negedge clk);
      exp_acc += int'(v[7:0]);
      chk(done, $sformatf("R2 R3 R7 vec%0d done", i), int'(done), 1);
      chk(max_flips == v[13:8], $sformatf("R3 R2 vec%0d max_flips", i), int'(max_flips), int'(v[13:8]));
      chk(!bad_msg && !s_ready, $sformatf("R2 R3 vec%0d no bad_msg", i), int'(bad_msg), 0);
      chk(int'(corr_acc) == exp_acc, $sformatf("R3 R8 vec%0d corr_acc", i), int'(corr_acc), exp_acc);
      chk(int'(fail_cnt) == exp_fail, $sformatf("R2 vec%0d fail_cnt", i), int'(fail_cnt), exp_fail);
      @(negedge clk);
      chk(!done, $sformatf("R7 vec%0d done pulse", i), int'(done), 0);
    end

    run_scan(16'h0085, 4, 3, 8, 5, 4, 1'b0, "scanA");
    run_scan(16'h8000, 0, 0, 0, 1, 0, 1'b1, "scanB R9 gaps");
    run_scan(16'h0000, 9, 9, 10, 0, 2, 1'b0, "scanC");
    run_scan(16'h7FFF, 2, 0, 0, 0, 0, 1'b1, "scanD max cleared R9");
    run_scan(16'h0080, 63, 70, 63, 0, 1, 1'b0, "scanE R10");

    do_start(1'b0, 16'h8282, 6'd8);
    @(negedge clk);
    exp_acc += 4;
    chk(!bad_msg && max_flips == 2, "R7 start clears bad_msg", int'(bad_msg), 0);
    chk(int'(corr_acc) == exp_acc, "R8 accumulator persists", int'(corr_acc), exp_acc);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule